// File: doc/BRIEF.md
# Multi-Target SPI Bus Master

This block is a serial bus master for a bus that carries several target devices. Each target has its own active-high select line. The block drives the serial clock and the outbound data line, and it samples the inbound data line. Software-side logic controls it through a single command channel with a valid/ready handshake. An OPEN command picks a target, a clock divisor and one of four clock modes, and raises that target's select. Any number of SHIFT commands follow, each moving 8 or 32 bits in both directions at once. A CLOSE command drops the select and records the minimum time that target must stay released.

Every SHIFT returns the word received from the target with a one-cycle done pulse. The block keeps a separate release timer for each target. An OPEN to a target that is still inside its release gap is stalled. An OPEN to any other target proceeds at once. A command that arrives out of order, or that names a target that does not exist, is dropped and reported with a one-cycle error pulse. An out-of-order command is, for example, a SHIFT with no transaction open, or an OPEN inside an open transaction.

Top module: `spim_multi_ctrl`

## Requirements
- R1: Bits are moved least significant first in both directions. `cmd_wide`=0 selects 8 bits and `cmd_wide`=1 selects 32 bits. After an 8-bit transfer, `rx_data_o[31:8]` reads zero.
- R2: `cmd_mode[1]` is the clock rest level and `cmd_mode[0]` is the phase. With phase 0, bit 0 is on `spi_dout_o` before the first clock edge, later bits change on trailing edges, and the input is sampled on leading edges. With phase 1, each bit is launched on a leading edge and sampled on the following trailing edge. Every transfer makes exactly 2×bits clock transitions.
- R3: Only the select bit of the addressed target (bit i for target i) is high during a transaction, so at most one select is ever high. The select holds steady throughout every transfer.
- R4: Outside a transfer, `spi_clk_o` rests at the rest level of the current or last transaction. After reset all selects are low, the clock is 0, and the done and error outputs are low.
- R5: A clock half-period lasts `cmd_div`+1 system cycles. The done pulse rises exactly 2×bits×(`cmd_div`+1) cycles after the SHIFT is accepted.
- R6: After a CLOSE carrying gap G is accepted at cycle E, an OPEN to the same target is not accepted before cycle E+G+1, and is accepted then if it is presented.
- R7: A release gap running for one target never delays an OPEN to a different target. The gaps of different targets run independently.
- R8: Command codes are 0=OPEN, 1=SHIFT and 2=CLOSE. The following are all rejected: code 3, SHIFT or CLOSE with no transaction open, OPEN inside a transaction, and OPEN naming a target index ≥ NSLV. A rejected command causes no select change and no clock activity, and raises `proto_err_o` for the one cycle after acceptance.
- R9: `cmd_ready` is low while a transfer is shifting. `rx_valid_o` is a single-cycle pulse, and `rx_data_o` holds the received word during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the reference tick for gaps |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 OPEN, 1 SHIFT, 2 CLOSE |
| cmd_slave | input | SEL_W | Target index for OPEN |
| cmd_div | input | DIV_W | Half-period divisor for OPEN |
| cmd_mode | input | 2 | {rest level, phase} for OPEN |
| cmd_wide | input | 1 | SHIFT size: 0 = 8 bits, 1 = 32 bits |
| cmd_data | input | 32 | SHIFT outbound word |
| cmd_gap | input | GAP_W | CLOSE minimum release time in cycles |
| rx_valid_o | output | 1 | Transfer done pulse |
| rx_data_o | output | 32 | Received word |
| proto_err_o | output | 1 | Rejected-command pulse |
| spi_clk_o | output | 1 | Serial clock |
| spi_dout_o | output | 1 | Outbound serial data |
| spi_din_i | input | 1 | Inbound serial data |
| spi_sel_o | output | NSLV | Active-high target selects |

## Verification
The bench builds the block with its default parameters: NSLV=3 (SEL_W=2), DIV_W=8 and GAP_W=16. The 2-bit index field can therefore name a target index of 3, which does not exist, so the invalid-target rejection can be reached. The sweep covers all four modes, divisors 0 and 2, and both widths. Each transaction carries two transfers and the target rotates across all three selects. Short gap values make the exact stall cycle of a same-target reopen directly measurable, while a different target is opened during another target's gap.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_CLOSE = 2'd2,
    OP_NONE  = 2'd3
  } spim_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_SHIFT = 2'd2
  } spim_st_e;

  localparam int unsigned MAX_BITS = 32;

  // bits moved by one transfer
  function automatic int unsigned bits_of(logic wide);
    return wide ? 32 : 8;
  endfunction

  // system cycles from accepting a transfer to its done pulse
  function automatic int unsigned xfer_cycles(logic wide, int unsigned div);
    return 2 * bits_of(wide) * (div + 1);
  endfunction
endpackage

// File: rtl/spim_gap_track.sv
module spim_gap_track #(
  parameter int NSLV  = 3,
  parameter int SEL_W = 2,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] load_idx,
  input  logic [GAP_W-1:0] load_val,
  output logic [NSLV-1:0]  clear
);
  for (genvar g = 0; g < NSLV; g++) begin : g_tgt
    logic [GAP_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 cnt <= '0;
      else if (load && load_idx == SEL_W'(g))     cnt <= load_val;
      else if (cnt != '0)                         cnt <= cnt - 1'b1;
    end
    assign clear[g] = (cnt == '0);
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  input  logic             pol,
  input  logic             pha,
  input  logic             wide,
  input  logic [DW-1:0]    tx,
  input  logic             din,
  output logic             busy,
  output logic             sclk,
  output logic             dout,
  output logic             done,
  output logic [DW-1:0]    rx,
  output logic             edge_ev
);
  localparam int EW = $clog2(2 * DW);

  logic [DIV_W-1:0] hc, div_q;
  logic [EW-1:0]    ecnt;
  logic [DW-1:0]    tx_q, rx_q;
  logic             pha_q, wide_q, sclk_q, dout_q, busy_q, done_q;
  logic             lead, last, nxt_ok;
  logic [EW-2:0]    k;

  assign lead    = ~ecnt[0];
  assign k       = ecnt[EW-1:1];
  assign edge_ev = busy_q && (hc == '0);
  assign last    = (ecnt == EW'(2 * bits_of(wide_q) - 1));
  assign nxt_ok  = (int'(k) + 1) < int'(bits_of(wide_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; hc <= '0; div_q <= '0; ecnt <= '0;
      tx_q <= '0; rx_q <= '0; pha_q <= 1'b0; wide_q <= 1'b0;
      sclk_q <= 1'b0; dout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        hc     <= div;
        div_q  <= div;
        ecnt   <= '0;
        sclk_q <= pol;
        tx_q   <= tx;
        rx_q   <= '0;
        pha_q  <= pha;
        wide_q <= wide;
        if (!pha) dout_q <= tx[0];
      end else if (busy_q) begin
        if (hc != '0) begin
          hc <= hc - 1'b1;
        end else begin
          hc     <= div_q;
          sclk_q <= ~sclk_q;
          ecnt   <= ecnt + 1'b1;
          if (lead ^ pha_q) rx_q[k] <= din;
          if (pha_q && lead) dout_q <= tx_q[k];
          else if (!pha_q && !lead && nxt_ok) dout_q <= tx_q[k + 1'b1];
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign dout = dout_q;
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/spim_seq.sv
module spim_seq
  import spim_pkg::*;
#(
  parameter int NSLV  = 3,
  parameter int SEL_W = 2,
  parameter int DIV_W = 8,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_slave,
  input  logic [DIV_W-1:0] cmd_div,
  input  logic [1:0]       cmd_mode,
  input  logic [GAP_W-1:0] cmd_gap,
  input  logic [NSLV-1:0]  gap_clear,
  input  logic             xfer_done,
  output logic             cmd_ready,
  output logic             xfer_go,
  output logic             gap_load,
  output logic [SEL_W-1:0] gap_idx,
  output logic [GAP_W-1:0] gap_val,
  output logic             proto_err,
  output logic [NSLV-1:0]  sel,
  output logic [DIV_W-1:0] txn_div,
  output logic [1:0]       txn_mode
);
  spim_st_e         st;
  logic [SEL_W-1:0] slave_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       mode_q;
  logic             err_q;
  logic             slave_ok, gap_ok, acc, bad;

  assign slave_ok = int'(cmd_slave) < NSLV;
  assign gap_ok   = slave_ok ? gap_clear[cmd_slave] : 1'b1;

  always_comb begin
    case (st)
      ST_IDLE:  cmd_ready = !(cmd_op == OP_OPEN && slave_ok && !gap_ok);
      ST_OPEN:  cmd_ready = 1'b1;
      default:  cmd_ready = 1'b0;
    endcase
  end

  assign acc = cmd_valid && cmd_ready;

  always_comb begin
    bad = 1'b0;
    if (st == ST_IDLE)      bad = !(cmd_op == OP_OPEN && slave_ok);
    else if (st == ST_OPEN) bad = !(cmd_op == OP_SHIFT || cmd_op == OP_CLOSE);
  end

  assign xfer_go  = acc && st == ST_OPEN && cmd_op == OP_SHIFT;
  assign gap_load = acc && st == ST_OPEN && cmd_op == OP_CLOSE;
  assign gap_idx  = slave_q;
  assign gap_val  = cmd_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; slave_q <= '0; div_q <= '0; mode_q <= '0; err_q <= 1'b0;
    end else begin
      err_q <= acc && bad;
      case (st)
        ST_IDLE: if (acc && !bad) begin
          st      <= ST_OPEN;
          slave_q <= cmd_slave;
          div_q   <= cmd_div;
          mode_q  <= cmd_mode;
        end
        ST_OPEN: begin
          if (xfer_go)       st <= ST_SHIFT;
          else if (gap_load) st <= ST_IDLE;
        end
        default: if (xfer_done) st <= ST_OPEN;
      endcase
    end
  end

  for (genvar g = 0; g < NSLV; g++) begin : g_sel
    assign sel[g] = (st != ST_IDLE) && (slave_q == SEL_W'(g));
  end

  assign proto_err = err_q;
  assign txn_div   = div_q;
  assign txn_mode  = mode_q;
endmodule

// File: rtl/spim_multi_ctrl.sv
module spim_multi_ctrl
  import spim_pkg::*;
#(
  parameter int NSLV  = 3,
  parameter int DIV_W = 8,
  parameter int GAP_W = 16,
  parameter int SEL_W = (NSLV > 1) ? $clog2(NSLV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_slave,
  input  logic [DIV_W-1:0] cmd_div,
  input  logic [1:0]       cmd_mode,
  input  logic             cmd_wide,
  input  logic [31:0]      cmd_data,
  input  logic [GAP_W-1:0] cmd_gap,
  output logic             rx_valid_o,
  output logic [31:0]      rx_data_o,
  output logic             proto_err_o,
  output logic             spi_clk_o,
  output logic             spi_dout_o,
  input  logic             spi_din_i,
  output logic [NSLV-1:0]  spi_sel_o
);
  logic             xfer_go, xfer_busy, xfer_done, shift_clk, edge_ev;
  logic             gap_load;
  logic [SEL_W-1:0] gap_idx;
  logic [GAP_W-1:0] gap_val;
  logic [NSLV-1:0]  gap_clear;
  logic [DIV_W-1:0] txn_div;
  logic [1:0]       txn_mode;

  spim_seq #(.NSLV(NSLV), .SEL_W(SEL_W), .DIV_W(DIV_W), .GAP_W(GAP_W)) u_seq (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_slave, .cmd_div, .cmd_mode, .cmd_gap,
    .gap_clear, .xfer_done, .cmd_ready, .xfer_go, .gap_load, .gap_idx, .gap_val,
    .proto_err(proto_err_o), .sel(spi_sel_o), .txn_div, .txn_mode
  );

  spim_gap_track #(.NSLV(NSLV), .SEL_W(SEL_W), .GAP_W(GAP_W)) u_gap (
    .clk, .rst_n, .load(gap_load), .load_idx(gap_idx), .load_val(gap_val), .clear(gap_clear)
  );

  spim_shift #(.DIV_W(DIV_W), .DW(MAX_BITS)) u_shift (
    .clk, .rst_n, .go(xfer_go), .div(txn_div), .pol(txn_mode[1]), .pha(txn_mode[0]),
    .wide(cmd_wide), .tx(cmd_data), .din(spi_din_i), .busy(xfer_busy),
    .sclk(shift_clk), .dout(spi_dout_o), .done(xfer_done), .rx(rx_data_o), .edge_ev(edge_ev)
  );

  assign spi_clk_o  = xfer_busy ? shift_clk : txn_mode[1];
  assign rx_valid_o = xfer_done;
endmodule

// File: rtl/spim_check.sv
module spim_check
  import spim_pkg::*;
#(
  parameter int NSLV  = 3,
  parameter int SEL_W = 2,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [SEL_W-1:0] cmd_slave,
  input logic [DIV_W-1:0] cmd_div,
  input logic             cmd_wide,
  input logic             rx_valid_o,
  input logic             proto_err_o,
  input logic             spi_clk_o,
  input logic [NSLV-1:0]  spi_sel_o,
  input logic             xfer_busy,
  input logic [NSLV-1:0]  gap_clear
);
  logic             acc, in_txn;
  logic [DIV_W-1:0] div_seen;
  logic             wide_seen;
  int unsigned      run_cnt;

  assign acc    = cmd_valid && cmd_ready;
  assign in_txn = (spi_sel_o != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_seen <= '0; wide_seen <= 1'b0; run_cnt <= 0;
    end else begin
      if (acc && !in_txn && cmd_op == 2'd0 && int'(cmd_slave) < NSLV) div_seen <= cmd_div;
      if (acc && in_txn && cmd_op == 2'd1) begin
        wide_seen <= cmd_wide;
        run_cnt   <= 0;
      end else if (run_cnt < 32'hFFFF_0000) begin
        run_cnt <= run_cnt + 1;
      end
    end
  end

  // R3
  a_r3_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spi_sel_o));
  // R3
  a_r3_select_steady: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> (spi_sel_o != '0) && $stable(spi_sel_o));
  // R4
  a_r4_clock_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_busy && $past(!xfer_busy) && in_txn && $past(in_txn)) |-> $stable(spi_clk_o));
  // R5
  a_r5_transfer_length: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> run_cnt == xfer_cycles(wide_seen, int'(div_seen)));
  // R6
  a_r6_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_txn && cmd_op == 2'd0 && int'(cmd_slave) < NSLV) |-> gap_clear[cmd_slave]);
  // R8
  a_r8_error_keeps_select: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> $stable(spi_sel_o));
  // R9
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> !cmd_ready);
  // R9
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind spim_multi_ctrl spim_check #(.NSLV(NSLV), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_spim_multi_ctrl.sv
module sim_spim_multi_ctrl;
  localparam int CLK_NS = 10;
  localparam int NSLV = 3, DIV_W = 8, GAP_W = 16, SEL_W = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [SEL_W-1:0] cmd_slave = 0;
  logic [DIV_W-1:0] cmd_div = 0;
  logic [1:0] cmd_mode = 0;
  logic cmd_wide = 0;
  logic [31:0] cmd_data = 0;
  logic [GAP_W-1:0] cmd_gap = 0;
  logic rx_valid_o, proto_err_o, spi_clk_o, spi_dout_o;
  logic [31:0] rx_data_o;
  logic spi_din_i = 0;
  logic [NSLV-1:0] spi_sel_o;

  spim_multi_ctrl u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // target model
  bit mon = 0, pol_e = 0, pha_e = 0;
  int nb = 8, tog = 0;
  logic [31:0] sw = 0, cap = 0;
  always @(spi_clk_o) begin
    if (mon) begin
      automatic bit lead = (spi_clk_o != pol_e);
      automatic int k = tog / 2;
      if (lead ^ pha_e) begin
        if (k < 32) cap[k] = spi_dout_o;
      end
      if (pha_e && lead) spi_din_i = sw[k];
      else if (!pha_e && !lead && k + 1 < nb) spi_din_i = sw[k+1];
      tog++;
    end
  end

  int acc_at, waits;
  task automatic send(input logic [1:0] op, input int slave, input int div, input logic [1:0] mode,
                      input bit wide, input logic [31:0] data, input int gap);
    @(negedge clk);
    cmd_op = op; cmd_slave = SEL_W'(slave); cmd_div = DIV_W'(div); cmd_mode = mode;
    cmd_wide = wide; cmd_data = data; cmd_gap = GAP_W'(gap); cmd_valid = 1;
    waits = 0;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #1; waits++;
    end
    acc_at = cyc + 1;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic xfer(input bit wide, input logic [31:0] data, input logic [31:0] swv,
                      input int div, input logic [1:0] mode, input int slave);
    automatic logic [31:0] mask = wide ? 32'hFFFF_FFFF : 32'h0000_00FF;
    automatic int a, got, lim;
    automatic bit rdy_seen = 0;
    nb = wide ? 32 : 8; sw = swv; cap = 0; tog = 0;
    pol_e = mode[1]; pha_e = mode[0];
    spi_din_i = mode[0] ? 1'b0 : swv[0];
    mon = 1;
    send(2'd1, 0, 0, 2'd0, wide, data, 0);
    a = acc_at; lim = 0;
    forever begin
      @(negedge clk);
      if (rx_valid_o) break;
      if (cmd_ready) rdy_seen = 1;
      lim++;
      if (lim > 5000) break;
    end
    got = cyc;
    mon = 0;
    chk(got == a + 2 * nb * (div + 1), "R5 done timing", got, a + 2 * nb * (div + 1));
    chk(rx_data_o == (swv & mask), "R1 received word", rx_data_o, swv & mask);
    chk((cap & mask) == (data & mask), "R1 sent word", cap & mask, data & mask);
    chk(tog == 2 * nb, "R2 clock transitions", tog, 2 * nb);
    chk(spi_sel_o == NSLV'(1 << slave), "R3 select", spi_sel_o, 1 << slave);
    chk(!rdy_seen, "R9 ready low while shifting", rdy_seen, 0);
    @(negedge clk);
    chk(!rx_valid_o, "R9 done single cycle", rx_valid_o, 0);
    chk(spi_clk_o == mode[1], "R4 clock rest level", spi_clk_o, mode[1]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    automatic int e0;
    repeat (5) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(spi_sel_o == 0, "R4 reset selects", spi_sel_o, 0);
    chk(spi_clk_o == 0, "R4 reset clock", spi_clk_o, 0);
    chk(!rx_valid_o && !proto_err_o, "R4 reset pulses", {rx_valid_o, proto_err_o}, 0);

    // sweep: modes x divisors, two transfers per transaction
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 3; d += 2) begin
        automatic int it = m * 2 + d / 2;
        automatic int s = it % NSLV;
        automatic logic [31:0] dv = 32'hA5C3_0F96 ^ (32'(it) * 32'h1357_9BDF);
        automatic logic [31:0] sv = {dv[14:0], dv[31:15]} ^ 32'h5A5A_33CC;
        send(2'd0, s, d, 2'(m), 0, 0, 0);
        chk(spi_sel_o == NSLV'(1 << s), "R3 select on open", spi_sel_o, 1 << s);
        xfer(0, dv, sv, d, 2'(m), s);
        xfer(1, ~dv, sv ^ 32'hFFFF_0000, d, 2'(m), s);
        send(2'd2, 0, 0, 2'd0, 0, 0, 0);
        chk(spi_sel_o == 0, "R3 release on close", spi_sel_o, 0);
        chk(spi_clk_o == m[1], "R4 rest after close", spi_clk_o, m[1]);
      end
    end

    // R6: same-target reopen stalls exactly
    send(2'd0, 0, 1, 2'd0, 0, 0, 0);
    send(2'd2, 0, 0, 2'd0, 0, 0, 10);
    e0 = acc_at;
    send(2'd0, 0, 1, 2'd0, 0, 0, 0);
    chk(acc_at == e0 + 11, "R6 same target stall", acc_at, e0 + 11);
    send(2'd2, 0, 0, 2'd0, 0, 0, 4);
    repeat (20) @(negedge clk);
    send(2'd0, 0, 1, 2'd0, 0, 0, 0);
    chk(waits == 0, "R6 no stall after gap elapsed", waits, 0);

    // R7: other target during a gap
    send(2'd2, 0, 0, 2'd0, 0, 0, 30);
    e0 = acc_at;
    send(2'd0, 1, 0, 2'd3, 0, 0, 0);
    chk(acc_at == e0 + 1, "R7 other target immediate", acc_at, e0 + 1);
    chk(spi_sel_o == 3'b010, "R7 other target selected", spi_sel_o, 3'b010);
    send(2'd2, 0, 0, 2'd0, 0, 0, 0);
    send(2'd0, 0, 0, 2'd0, 0, 0, 0);
    chk(acc_at == e0 + 31, "R6 gap kept across other target", acc_at, e0 + 31);
    send(2'd2, 0, 0, 2'd0, 0, 0, 0);

    // R8: protocol errors
    send(2'd1, 0, 0, 2'd0, 0, 32'hFF, 0);
    chk(proto_err_o == 1, "R8 shift while idle", proto_err_o, 1);
    chk(spi_sel_o == 0, "R8 idle shift no select", spi_sel_o, 0);
    repeat (40) @(negedge clk);
    chk(!rx_valid_o && spi_clk_o == 0, "R8 idle shift no transfer", {rx_valid_o, spi_clk_o}, 0);
    send(2'd2, 0, 0, 2'd0, 0, 0, 0);
    chk(proto_err_o == 1, "R8 close while idle", proto_err_o, 1);
    send(2'd3, 0, 0, 2'd0, 0, 0, 0);
    chk(proto_err_o == 1, "R8 unused code", proto_err_o, 1);
    send(2'd0, 3, 0, 2'd2, 0, 0, 0);
    chk(proto_err_o == 1, "R8 bad target index", proto_err_o, 1);
    chk(spi_sel_o == 0 && spi_clk_o == 0, "R8 bad index no select", {spi_sel_o, spi_clk_o}, 0);
    send(2'd0, 2, 0, 2'd0, 0, 0, 0);
    chk(proto_err_o == 0, "R8 valid open no error", proto_err_o, 0);
    send(2'd0, 1, 0, 2'd2, 0, 0, 0);
    chk(proto_err_o == 1, "R8 open inside transaction", proto_err_o, 1);
    chk(spi_sel_o == 3'b100, "R8 select unchanged", spi_sel_o, 3'b100);
    chk(spi_clk_o == 0, "R8 mode unchanged", spi_clk_o, 0);
    xfer(0, 32'h0000_003C, 32'h0000_00C5, 0, 2'd0, 2);
    send(2'd2, 0, 0, 2'd0, 0, 0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule